// File: doc/BRIEF.md
# USB Full-Speed Frame Timer

This block produces the 1 ms frame timebase of a full-speed USB host. It is advanced by a single-cycle enable that pulses once per 12 Mbit/s bit time. A down counter holds the bit times left in the current frame. When it runs out, it reloads from a software-written interval register, advances a 16-bit frame number and issues a one-cycle start-of-frame pulse.

A second software-written value is a low-speed commit threshold. It is compared against the remaining count so that the transaction scheduler knows whether a worst-case 8-byte low-speed packet can still start before end of frame. Counting only advances while the host is in its operational state. Register writes are simple write-enable plus data strobes.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the interval reads 11999, the remaining count reads 11999, the frame number reads 0, the start-of-frame output is low and the threshold reads 1576.
- R2: On a clock edge where bit_tick_i and run_i are both high and the remaining count is non-zero, the remaining count decreases by exactly one and the frame number is unchanged.
- R3: On a clock edge where bit_tick_i and run_i are both high and the remaining count is zero, the remaining count loads the interval value held before that edge and the frame number increases by one.
- R4: sof_o is high for exactly the one cycle that follows each reload edge of R3, and is low at all other times.
- R5: The frame number wraps from 65535 to 0 on reload.
- R6: A write to the interval changes interval_o on the next edge but leaves the remaining count of the current frame untouched; the new value is first used at the next reload.
- R7: ls_commit_o is high exactly when the remaining count is strictly greater than the threshold; equality gives low.
- R8: While run_i is low, the remaining count and frame number hold and sof_o stays low, whatever bit_tick_i does.
- R9: While bit_tick_i is low, the remaining count and frame number hold.
- R10: With the reset interval and a tick every cycle, start-of-frame pulses are exactly 12000 ticks apart, and the first comes 12000 ticks after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One-cycle enable per full-speed bit time |
| run_i | input | 1 | High while the host is operational |
| ivl_we_i | input | 1 | Interval write strobe |
| ivl_wdata_i | input | 14 | Interval write data |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_wdata_i | input | 11 | Threshold write data |
| interval_o | output | 14 | Current interval register |
| threshold_o | output | 11 | Current low-speed threshold register |
| remaining_o | output | 14 | Bit times left in the frame |
| frame_num_o | output | 16 | Frame number |
| sof_o | output | 1 | Start-of-frame pulse |
| ls_commit_o | output | 1 | Low-speed packet may still start |

## Verification
On every cycle the assertions check the decrement, the reload from the prior interval together with the frame advance, the origin of each start-of-frame pulse, the hold while stopped, and the threshold comparison. The bench's scenarios are needed for the things a single-edge property cannot show. These are the reset values, the 12000-tick spacing of frames, a wrap of the frame number after 65536 frames, the deferred effect of an interval write made mid-frame, and a sweep of threshold values through the equality point.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int unsigned FTC_REM_W   = 14;
  localparam int unsigned FTC_FN_W    = 16;
  localparam int unsigned FTC_THR_W   = 11;
  localparam int unsigned FTC_IVL_DEF = 11999;
  localparam int unsigned FTC_THR_DEF = 1576;
endpackage

// File: rtl/ftc_cfg_regs.sv
module ftc_cfg_regs #(
  parameter int unsigned REM_W   = ftc_pkg::FTC_REM_W,
  parameter int unsigned THR_W   = ftc_pkg::FTC_THR_W,
  parameter int unsigned IVL_DEF = ftc_pkg::FTC_IVL_DEF,
  parameter int unsigned THR_DEF = ftc_pkg::FTC_THR_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ivl_we_i,
  input  logic [REM_W-1:0] ivl_wdata_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_wdata_i,
  output logic [REM_W-1:0] interval_o,
  output logic [THR_W-1:0] threshold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      interval_o  <= REM_W'(IVL_DEF);
      threshold_o <= THR_W'(THR_DEF);
    end else begin
      if (ivl_we_i) interval_o  <= ivl_wdata_i;
      if (thr_we_i) threshold_o <= thr_wdata_i;
    end
  end
endmodule

// File: rtl/ftc_rem_ctr.sv
module ftc_rem_ctr #(
  parameter int unsigned REM_W   = ftc_pkg::FTC_REM_W,
  parameter int unsigned IVL_DEF = ftc_pkg::FTC_IVL_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [REM_W-1:0] interval_i,
  output logic [REM_W-1:0] rem_o,
  output logic             reload_o
);
  assign reload_o = step_i && (rem_o == '0);

  // reload takes the register value present before the edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rem_o <= REM_W'(IVL_DEF);
    else if (reload_o) rem_o <= interval_i;
    else if (step_i)   rem_o <= rem_o - REM_W'(1);
  end
endmodule

// File: rtl/ftc_frame_ctr.sv
module ftc_frame_ctr #(
  parameter int unsigned FN_W = ftc_pkg::FTC_FN_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  output logic [FN_W-1:0] frame_o,
  output logic            sof_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      sof_o   <= 1'b0;
    end else begin
      sof_o <= adv_i;
      if (adv_i) frame_o <= frame_o + FN_W'(1);
    end
  end
endmodule

// File: rtl/ftc_ls_gate.sv
module ftc_ls_gate #(
  parameter int unsigned REM_W = ftc_pkg::FTC_REM_W,
  parameter int unsigned THR_W = ftc_pkg::FTC_THR_W
) (
  input  logic [REM_W-1:0] rem_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             commit_o
);
  localparam int unsigned CMP_W = (REM_W > THR_W) ? REM_W : THR_W;
  logic [CMP_W-1:0] rem_x, thr_x;

  generate
    if (REM_W >= THR_W) begin : g_wide_rem
      assign rem_x = rem_i;
      assign thr_x = {{(CMP_W-THR_W){1'b0}}, thr_i};
    end else begin : g_wide_thr
      assign rem_x = {{(CMP_W-REM_W){1'b0}}, rem_i};
      assign thr_x = thr_i;
    end
  endgenerate

  assign commit_o = rem_x > thr_x;
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int unsigned REM_W   = ftc_pkg::FTC_REM_W,
  parameter int unsigned FN_W    = ftc_pkg::FTC_FN_W,
  parameter int unsigned THR_W   = ftc_pkg::FTC_THR_W,
  parameter int unsigned IVL_DEF = ftc_pkg::FTC_IVL_DEF,
  parameter int unsigned THR_DEF = ftc_pkg::FTC_THR_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             run_i,
  input  logic             ivl_we_i,
  input  logic [REM_W-1:0] ivl_wdata_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_wdata_i,
  output logic [REM_W-1:0] interval_o,
  output logic [THR_W-1:0] threshold_o,
  output logic [REM_W-1:0] remaining_o,
  output logic [FN_W-1:0]  frame_num_o,
  output logic             sof_o,
  output logic             ls_commit_o
);
  logic step, reload;

  assign step = bit_tick_i && run_i;

  ftc_cfg_regs #(
    .REM_W(REM_W), .THR_W(THR_W), .IVL_DEF(IVL_DEF), .THR_DEF(THR_DEF)
  ) u_cfg (
    .clk_i, .rst_ni,
    .ivl_we_i, .ivl_wdata_i, .thr_we_i, .thr_wdata_i,
    .interval_o, .threshold_o
  );

  ftc_rem_ctr #(.REM_W(REM_W), .IVL_DEF(IVL_DEF)) u_rem (
    .clk_i, .rst_ni,
    .step_i(step), .interval_i(interval_o),
    .rem_o(remaining_o), .reload_o(reload)
  );

  ftc_frame_ctr #(.FN_W(FN_W)) u_fn (
    .clk_i, .rst_ni,
    .adv_i(reload), .frame_o(frame_num_o), .sof_o(sof_o)
  );

  ftc_ls_gate #(.REM_W(REM_W), .THR_W(THR_W)) u_ls (
    .rem_i(remaining_o), .thr_i(threshold_o), .commit_o(ls_commit_o)
  );
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int unsigned REM_W = ftc_pkg::FTC_REM_W,
  parameter int unsigned FN_W  = ftc_pkg::FTC_FN_W,
  parameter int unsigned THR_W = ftc_pkg::FTC_THR_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_tick_i,
  input logic             run_i,
  input logic [REM_W-1:0] interval_o,
  input logic [THR_W-1:0] threshold_o,
  input logic [REM_W-1:0] remaining_o,
  input logic [FN_W-1:0]  frame_num_o,
  input logic             sof_o,
  input logic             ls_commit_o
);
  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_i && run_i && remaining_o != '0) |=>
      (remaining_o == REM_W'($past(remaining_o) - 1'b1)) && $stable(frame_num_o));

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_i && run_i && remaining_o == '0) |=>
      (remaining_o == $past(interval_o)) &&
      (frame_num_o == FN_W'($past(frame_num_o) + 1'b1)));

  p_sof_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> $past(bit_tick_i && run_i && remaining_o == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(remaining_o) && $stable(frame_num_o) && !sof_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(remaining_o) && $stable(frame_num_o));

  p_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_commit_o == (32'(remaining_o) > 32'(threshold_o)));
endmodule

bind usb_frame_timer ftc_checker #(.REM_W(REM_W), .FN_W(FN_W), .THR_W(THR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_tick_i(bit_tick_i), .run_i(run_i),
  .interval_o(interval_o), .threshold_o(threshold_o), .remaining_o(remaining_o),
  .frame_num_o(frame_num_o), .sof_o(sof_o), .ls_commit_o(ls_commit_o)
);

// File: tb/usb_frame_timer_bench.sv
module usb_frame_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b0, ivl_we = 1'b0, thr_we = 1'b0;
  logic [13:0] ivl_wd = '0;
  logic [10:0] thr_wd = '0;
  logic [13:0] interval_o, remaining_o;
  logic [10:0] threshold_o;
  logic [15:0] frame_num_o;
  logic sof_o, ls_commit_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // expected state
  int exp_ivl = 11999, exp_thr = 1576, exp_rem = 11999, exp_fn = 0;
  bit exp_sof = 0;
  int ticks_since_sof = 0, sof_seen = 0;

  always #2.5 clk = ~clk;

  usb_frame_timer u_usb_frame_timer (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .run_i(run),
    .ivl_we_i(ivl_we), .ivl_wdata_i(ivl_wd), .thr_we_i(thr_we), .thr_wdata_i(thr_wd),
    .interval_o(interval_o), .threshold_o(threshold_o), .remaining_o(remaining_o),
    .frame_num_o(frame_num_o), .sof_o(sof_o), .ls_commit_o(ls_commit_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit rn, input bit iwe, input int iv,
                      input bit twe, input int tv, input bit check_spacing);
    string rreq;
    bit wrapped;
    @(negedge clk);
    tick = tk; run = rn; ivl_we = iwe; ivl_wd = 14'(iv); thr_we = twe; thr_wd = 11'(tv);
    exp_sof = 0;
    wrapped = 0;
    if (!rn)      rreq = "R8";
    else if (!tk) rreq = "R9";
    else if (exp_rem == 0) begin
      rreq = "R3";
      wrapped = (exp_fn == 65535);
      exp_rem = exp_ivl;
      exp_fn = (exp_fn + 1) % 65536;
      exp_sof = 1;
    end else begin
      rreq = "R2";
      exp_rem = exp_rem - 1;
    end
    if (tk && rn) ticks_since_sof++;
    if (iwe) exp_ivl = iv;
    if (twe) exp_thr = tv;
    @(posedge clk);
    #1;
    chk({rreq, " remaining"}, remaining_o, exp_rem);
    chk({rreq, " frame"}, frame_num_o, exp_fn);
    chk("R4 sof", sof_o, exp_sof);
    chk("R6 interval", interval_o, exp_ivl);
    chk("R7 commit", ls_commit_o, exp_rem > exp_thr);
    if (wrapped) chk("R5 wrap", frame_num_o, 0);
    if (sof_o) begin
      if (check_spacing) chk("R10 spacing", ticks_since_sof, 12000);
      ticks_since_sof = 0;
      sof_seen++;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 interval", interval_o, 11999);
    chk("R1 remaining", remaining_o, 11999);
    chk("R1 frame", frame_num_o, 0);
    chk("R1 sof", sof_o, 0);
    chk("R1 threshold", threshold_o, 1576);
    @(negedge clk);
    rst_n = 1'b1;

    // R9 no tick, R8 stopped with ticks
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0);

    // R10 two default frames
    for (int i = 0; i < 24000; i++) step(1, 1, 0, 0, 0, 0, 1);
    chk("R10 frames", sof_seen, 2);

    // R6 mid-frame interval write
    for (int i = 0; i < 100; i++) step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 9, 0, 0, 0);
    for (int i = 0; i < 11950; i++) step(1, 1, 0, 0, 0, 0, 0);
    chk("R6 short frames", remaining_o <= 9, 1);

    // R7 threshold sweep through equality
    for (int t = 0; t < 12; t++) begin
      step(1, 1, 0, 0, 1, t, 0);
      for (int i = 0; i < 22; i++) step(1, 1, 0, 0, 0, 0, 0);
    end

    // irregular tick and run pattern
    for (int i = 0; i < 200; i++) step((i % 3) != 0, (i % 7) != 3, 0, 0, 0, 0, 0);

    // R5 frame number wrap with a zero interval
    step(1, 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 65560; i++) step(1, 1, 0, 0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule